// File: doc/BRIEF.md
# Write-Back Data Cache with Management Hints

This block is a small two-way set-associative data cache with write-back and write-allocate policy. It sits between a processor load/store port and a line-wide memory port. Besides word loads and stores, it accepts five cache-management commands:

- **Prefetch** warms a line.
- **Allocate-zero** claims a line as all-zero without reading memory.
- **Invalidate** discards a line even when it is dirty.
- **Flush** pushes a line out of the cache.
- **Load-last** returns data and marks the line as the next one to be replaced.

Allocate-zero and invalidate change what memory-visible reads return. Load-last only changes the replacement order.

Only one command is handled at a time. The processor side uses a valid/ready handshake. The controller drops ready from the cycle after acceptance until the command completes. A load result appears on `cpu_rdata` together with a one-cycle `cpu_rvalid` pulse. The memory side carries whole lines: one request per line transfer, held until acknowledged. Each set keeps a single replacement bit that names the way to evict next.

Top module: `hint_wb_cache`

## Requirements
- R1: A load (opcode 3'd0) returns the addressed 32-bit word with a one-cycle `cpu_rvalid` pulse. On a hit there is no memory traffic and the result is present one cycle after acceptance. On a miss exactly one line read is made, and the result is present four cycles after acceptance when the victim is clean.
- R2: A store (opcode 3'd1) writes its word into the line, allocating the line with one line read on a miss. It makes no memory write until that line is later evicted. The other words of an allocated line keep their memory values.
- R3: On a miss, an invalid way of the set is chosen before a valid one. Otherwise the way named by the set's replacement bit is chosen. Loads, stores, prefetches and allocate-zero make the accessed way most recently used.
- R4: A dirty victim is written back as a whole line to its own line-aligned address before a fill or an allocate-zero proceeds. A clean victim is dropped with no write.
- R5: A prefetch (opcode 3'd2) of an absent line makes one line read. A prefetch of a present line makes no traffic. Neither kind raises `cpu_rvalid`.
- R6: Allocate-zero (opcode 3'd3) leaves every word of the line reading zero, marks the line dirty and never issues a memory read.
- R7: Invalidate (opcode 3'd4) of a present line drops it without a write-back, even when it is dirty. A later load then reads the memory copy.
- R8: Flush (opcode 3'd5) of a dirty line writes the line back and then invalidates it. Flush of a clean line invalidates it with no traffic. Either way, the next access to that line misses.
- R9: Invalidate or flush of an absent line completes with no memory traffic and no `cpu_rvalid`.
- R10: Load-last (opcode 3'd6) returns data like a load, filling the line first on a miss. It sets the replacement bit so that this line is the next victim of its set, while the line stays valid.
- R11: `cpu_ready` is low from the cycle after acceptance until the command completes. While it is low, no command is accepted. A memory request holds its address, direction and data steady until `mem_ack`.
- R12: After reset every line is invalid, `cpu_ready` is high, and `mem_req` and `cpu_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Command present |
| cpu_ready | output | 1 | Controller idle, command taken at this edge |
| cpu_op | input | 3 | Command code (see requirements) |
| cpu_addr | input | ADDR_W (16) | Byte address, word aligned |
| cpu_wdata | input | WORD_W (32) | Store data |
| cpu_rdata | output | WORD_W (32) | Load result, held until the next load |
| cpu_rvalid | output | 1 | One-cycle pulse marking a new load result |
| mem_req | output | 1 | Memory line request, held until acknowledged |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | ADDR_W (16) | Line-aligned memory address |
| mem_wdata | output | LINE_WORDS*WORD_W (128) | Line being written back |
| mem_ack | input | 1 | One-cycle acknowledge, read data valid with it |
| mem_rdata | input | LINE_WORDS*WORD_W (128) | Line returned for a read |

## Verification
Take the edge that accepts a command as cycle 0.

- **Hits:** a hit finishes at the next edge, so result, `cpu_rvalid` and restored `cpu_ready` are all due one cycle later.
- **Clean misses:** a miss adds a request cycle, an acknowledge cycle from the bench memory and a re-lookup. Against that memory a clean-victim miss completes four cycles after acceptance.
- **Dirty-victim misses:** these add three more cycles for the write-back.

The bench drives inputs and samples outputs on falling edges. It counts the falling edges until `cpu_ready` returns and captures `cpu_rvalid` and `cpu_rdata` on exactly that edge. It compares the memory model's read and write counters before and after each command, so traffic that is absent is checked as firmly as traffic that is present.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

   typedef enum logic [2:0] {
      OP_LOAD     = 3'd0,
      OP_STORE    = 3'd1,
      OP_PREFETCH = 3'd2,
      OP_ZERO     = 3'd3,
      OP_INVAL    = 3'd4,
      OP_FLUSH    = 3'd5,
      OP_LOADLAST = 3'd6
   } hwc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_WBACK  = 2'd2,
      ST_FILL   = 2'd3
   } hwc_state_e;

endpackage

// File: rtl/hwc_tag_store.sv
module hwc_tag_store #(
   parameter int SETS  = 8,
   parameter int SET_W = 3,
   parameter int WAYS  = 2,
   parameter int TAG_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             hit,
   output logic             hit_way,
   output logic             hit_dirty,
   output logic             vic_way,
   output logic             vic_valid,
   output logic             vic_dirty,
   output logic [TAG_W-1:0] vic_tag,
   input  logic             ent_we,
   input  logic             ent_way,
   input  logic             ent_valid,
   input  logic             ent_dirty,
   input  logic             lru_we,
   input  logic             lru_val
);

   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [WAYS-1:0]  valid_q [SETS];
   logic [WAYS-1:0]  dirty_q [SETS];
   logic [SETS-1:0]  lru_q;
   logic [WAYS-1:0]  hit_vec;

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_cmp
         assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
      end
   endgenerate

   assign hit       = |hit_vec;
   assign hit_way   = hit_vec[1];
   assign hit_dirty = dirty_q[lk_set][hit_way];

   always_comb begin
      if (!valid_q[lk_set][0])      vic_way = 1'b0;
      else if (!valid_q[lk_set][1]) vic_way = 1'b1;
      else                          vic_way = lru_q[lk_set];
   end

   assign vic_valid = valid_q[lk_set][vic_way];
   assign vic_dirty = dirty_q[lk_set][vic_way];
   assign vic_tag   = tag_q[lk_set][vic_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            valid_q[s] <= '0;
            dirty_q[s] <= '0;
         end
         lru_q <= '0;
      end else begin
         if (ent_we) begin
            valid_q[lk_set][ent_way] <= ent_valid;
            dirty_q[lk_set][ent_way] <= ent_dirty;
         end
         if (lru_we) lru_q[lk_set] <= lru_val;
      end
   end

   always_ff @(posedge clk) begin
      if (ent_we && ent_valid) tag_q[lk_set][ent_way] <= lk_tag;
   end

   AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)) else $error("two ways hold one tag"); // R3

   generate
      for (genvar s = 0; s < SETS; s++) begin : g_chk
         AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            (dirty_q[s] & ~valid_q[s]) == '0) else $error("dirty invalid line"); // R4
      end
   endgenerate

endmodule

// File: rtl/hwc_data_store.sv
module hwc_data_store #(
   parameter int SETS       = 8,
   parameter int SET_W      = 3,
   parameter int LINE_WORDS = 4,
   parameter int WSEL_W     = 2,
   parameter int WORD_W     = 32,
   parameter int LINE_W     = LINE_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic [SET_W-1:0]  set,
   input  logic [WSEL_W-1:0] word_sel,
   input  logic              rd_way,
   output logic [LINE_W-1:0] rd_line,
   output logic [WORD_W-1:0] rd_word,
   input  logic              wr_way,
   input  logic              line_we,
   input  logic [LINE_W-1:0] line_wdata,
   input  logic              word_we,
   input  logic [WORD_W-1:0] word_wdata
);

   logic [LINE_W-1:0] line_q [SETS][2];
   logic [LINE_W-1:0] cur_line;
   logic [LINE_W-1:0] merged;

   assign rd_line  = line_q[set][rd_way];
   assign cur_line = line_q[set][wr_way];

   generate
      for (genvar i = 0; i < LINE_WORDS; i++) begin : g_lane
         assign merged[i*WORD_W +: WORD_W] =
            (word_sel == WSEL_W'(i)) ? word_wdata : cur_line[i*WORD_W +: WORD_W];
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < LINE_WORDS; i++) begin
         if (word_sel == WSEL_W'(i)) rd_word = rd_line[i*WORD_W +: WORD_W];
      end
   end

   always_ff @(posedge clk) begin
      if (line_we)      line_q[set][wr_way] <= line_wdata;
      else if (word_we) line_q[set][wr_way] <= merged;
   end

endmodule

// File: rtl/hwc_ctrl.sv
module hwc_ctrl
   import hwc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int WORD_W = 32,
   parameter int LINE_W = 128,
   parameter int OFF_W  = 4,
   parameter int WSEL_W = 2,
   parameter int BYTE_W = 2,
   parameter int SET_W  = 3,
   parameter int TAG_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   output logic              cpu_ready,
   input  logic [2:0]        cpu_op,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_rvalid,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [LINE_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [LINE_W-1:0] mem_rdata,
   output logic [SET_W-1:0]  lk_set,
   output logic [TAG_W-1:0]  lk_tag,
   output logic [WSEL_W-1:0] word_sel,
   input  logic              hit,
   input  logic              hit_way,
   input  logic              hit_dirty,
   input  logic              vic_way,
   input  logic              vic_valid,
   input  logic              vic_dirty,
   input  logic [TAG_W-1:0]  vic_tag,
   output logic              ent_we,
   output logic              ent_way,
   output logic              ent_valid,
   output logic              ent_dirty,
   output logic              lru_we,
   output logic              lru_val,
   output logic              d_rd_way,
   input  logic [LINE_W-1:0] d_rd_line,
   input  logic [WORD_W-1:0] d_rd_word,
   output logic              d_line_we,
   output logic [LINE_W-1:0] d_line_wdata,
   output logic              d_word_we,
   output logic [WORD_W-1:0] d_word_wdata
);

   hwc_state_e        state_q, state_d;
   hwc_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] wdata_q;
   logic              tgt_q, tgt_d;
   logic              rv_d;
   logic              mreq_set, mwe_set;
   logic [ADDR_W-1:0] maddr_set;
   logic              is_alloc;

   assign lk_set       = addr_q[OFF_W +: SET_W];
   assign lk_tag       = addr_q[ADDR_W-1 -: TAG_W];
   assign word_sel     = addr_q[BYTE_W +: WSEL_W];
   assign cpu_ready    = (state_q == ST_IDLE);
   assign d_word_wdata = wdata_q;
   assign d_rd_way     = (state_q == ST_WBACK) ? tgt_q : hit_way;
   assign mem_wdata    = d_rd_line;

   assign is_alloc = (op_q == OP_LOAD) || (op_q == OP_STORE) || (op_q == OP_PREFETCH) ||
                     (op_q == OP_ZERO) || (op_q == OP_LOADLAST);

   always_comb begin
      state_d      = state_q;
      tgt_d        = tgt_q;
      rv_d         = 1'b0;
      ent_we       = 1'b0;
      ent_way      = hit_way;
      ent_valid    = 1'b1;
      ent_dirty    = 1'b0;
      lru_we       = 1'b0;
      lru_val      = ~hit_way;
      d_line_we    = 1'b0;
      d_line_wdata = '0;
      d_word_we    = 1'b0;
      mreq_set     = 1'b0;
      mwe_set      = 1'b0;
      maddr_set    = '0;
      case (state_q)
         ST_IDLE: if (cpu_valid) state_d = ST_LOOKUP;
         ST_LOOKUP: begin
            state_d = ST_IDLE;
            if (is_alloc && hit) begin
               lru_we  = 1'b1;
               lru_val = (op_q == OP_LOADLAST) ? hit_way : ~hit_way;
               if (op_q == OP_STORE) begin
                  ent_we    = 1'b1;
                  ent_dirty = 1'b1;
                  d_word_we = 1'b1;
               end
               if (op_q == OP_ZERO) begin
                  ent_we    = 1'b1;
                  ent_dirty = 1'b1;
                  d_line_we = 1'b1;
               end
               rv_d = (op_q == OP_LOAD) || (op_q == OP_LOADLAST);
            end else if (is_alloc) begin
               tgt_d = vic_way;
               if (vic_valid && vic_dirty) begin
                  state_d   = ST_WBACK;
                  mreq_set  = 1'b1;
                  mwe_set   = 1'b1;
                  maddr_set = {vic_tag, lk_set, {OFF_W{1'b0}}};
               end else if (op_q == OP_ZERO) begin
                  ent_we    = 1'b1;
                  ent_way   = vic_way;
                  ent_dirty = 1'b1;
                  d_line_we = 1'b1;
                  lru_we    = 1'b1;
                  lru_val   = ~vic_way;
               end else begin
                  state_d   = ST_FILL;
                  mreq_set  = 1'b1;
                  maddr_set = {lk_tag, lk_set, {OFF_W{1'b0}}};
               end
            end else if (((op_q == OP_INVAL) || (op_q == OP_FLUSH)) && hit) begin
               if ((op_q == OP_FLUSH) && hit_dirty) begin
                  state_d   = ST_WBACK;
                  tgt_d     = hit_way;
                  mreq_set  = 1'b1;
                  mwe_set   = 1'b1;
                  maddr_set = {lk_tag, lk_set, {OFF_W{1'b0}}};
               end else begin
                  ent_we    = 1'b1;
                  ent_valid = 1'b0;
               end
            end
         end
         ST_WBACK: if (mem_ack) begin
            ent_we    = 1'b1;
            ent_way   = tgt_q;
            ent_valid = 1'b0;
            state_d   = (op_q == OP_FLUSH) ? ST_IDLE : ST_LOOKUP;
         end
         ST_FILL: if (mem_ack) begin
            ent_we       = 1'b1;
            ent_way      = tgt_q;
            d_line_we    = 1'b1;
            d_line_wdata = mem_rdata;
            state_d      = ST_LOOKUP;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_q       <= OP_LOAD;
         addr_q     <= '0;
         wdata_q    <= '0;
         tgt_q      <= 1'b0;
         cpu_rvalid <= 1'b0;
         cpu_rdata  <= '0;
         mem_req    <= 1'b0;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
      end else begin
         state_q    <= state_d;
         tgt_q      <= tgt_d;
         cpu_rvalid <= rv_d;
         if (rv_d) cpu_rdata <= d_rd_word;
         if ((state_q == ST_IDLE) && cpu_valid) begin
            op_q    <= hwc_op_e'(cpu_op);
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
         end
         if (mreq_set) begin
            mem_req  <= 1'b1;
            mem_we   <= mwe_set;
            mem_addr <= maddr_set;
         end else if (mem_ack) begin
            mem_req <= 1'b0;
         end
      end
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
      else $error("memory request changed before ack"); // R11
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !cpu_ready) else $error("ready while memory busy"); // R11
   AST_ZERO_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (op_q != OP_ZERO)) else $error("allocate-zero read memory"); // R6
   AST_INVAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (op_q != OP_INVAL)) else $error("invalidate made traffic"); // R7
   AST_FLUSH_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && (op_q == OP_FLUSH)) |-> mem_we) else $error("flush read memory"); // R8
   AST_RVALID_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> ((op_q == OP_LOAD) || (op_q == OP_LOADLAST))) else $error("data returned for non-load"); // R5

endmodule

// File: rtl/hint_wb_cache.sv
module hint_wb_cache #(
   parameter int ADDR_W     = 16,
   parameter int WORD_W     = 32,
   parameter int LINE_WORDS = 4,
   parameter int SETS       = 8,
   parameter int WAYS       = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cpu_valid,
   output logic                         cpu_ready,
   input  logic [2:0]                   cpu_op,
   input  logic [ADDR_W-1:0]            cpu_addr,
   input  logic [WORD_W-1:0]            cpu_wdata,
   output logic [WORD_W-1:0]            cpu_rdata,
   output logic                         cpu_rvalid,
   output logic                         mem_req,
   output logic                         mem_we,
   output logic [ADDR_W-1:0]            mem_addr,
   output logic [LINE_WORDS*WORD_W-1:0] mem_wdata,
   input  logic                         mem_ack,
   input  logic [LINE_WORDS*WORD_W-1:0] mem_rdata
);

   localparam int LINE_W = LINE_WORDS * WORD_W;
   localparam int BYTE_W = $clog2(WORD_W / 8);
   localparam int WSEL_W = $clog2(LINE_WORDS);
   localparam int OFF_W  = BYTE_W + WSEL_W;
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;

   generate
      if (WAYS != 2) begin : g_bad_ways
         $error("one replacement bit per set needs exactly two ways");
      end
      if ((SETS < 2) || ((SETS & (SETS - 1)) != 0)) begin : g_bad_sets
         $error("SETS must be a power of two of at least 2");
      end
      if ((LINE_WORDS < 2) || ((LINE_WORDS & (LINE_WORDS - 1)) != 0)) begin : g_bad_line
         $error("LINE_WORDS must be a power of two of at least 2");
      end
      if ((WORD_W < 8) || ((WORD_W & (WORD_W - 1)) != 0)) begin : g_bad_word
         $error("WORD_W must be a power of two of at least 8");
      end
      if (TAG_W < 1) begin : g_bad_addr
         $error("ADDR_W too small for the chosen geometry");
      end
   endgenerate

   logic [SET_W-1:0]  lk_set;
   logic [TAG_W-1:0]  lk_tag;
   logic [WSEL_W-1:0] word_sel;
   logic              hit, hit_way, hit_dirty;
   logic              vic_way, vic_valid, vic_dirty;
   logic [TAG_W-1:0]  vic_tag;
   logic              ent_we, ent_way, ent_valid, ent_dirty;
   logic              lru_we, lru_val;
   logic              d_rd_way, d_line_we, d_word_we;
   logic [LINE_W-1:0] d_rd_line, d_line_wdata;
   logic [WORD_W-1:0] d_rd_word, d_word_wdata;

   hwc_ctrl #(
      .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_W(LINE_W), .OFF_W(OFF_W),
      .WSEL_W(WSEL_W), .BYTE_W(BYTE_W), .SET_W(SET_W), .TAG_W(TAG_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_op(cpu_op),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .cpu_rvalid(cpu_rvalid),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .lk_set(lk_set), .lk_tag(lk_tag), .word_sel(word_sel),
      .hit(hit), .hit_way(hit_way), .hit_dirty(hit_dirty),
      .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
      .ent_we(ent_we), .ent_way(ent_way), .ent_valid(ent_valid), .ent_dirty(ent_dirty),
      .lru_we(lru_we), .lru_val(lru_val),
      .d_rd_way(d_rd_way), .d_rd_line(d_rd_line), .d_rd_word(d_rd_word),
      .d_line_we(d_line_we), .d_line_wdata(d_line_wdata),
      .d_word_we(d_word_we), .d_word_wdata(d_word_wdata)
   );

   hwc_tag_store #(
      .SETS(SETS), .SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W)
   ) u_tags (
      .clk(clk), .rst_n(rst_n), .lk_set(lk_set), .lk_tag(lk_tag),
      .hit(hit), .hit_way(hit_way), .hit_dirty(hit_dirty),
      .vic_way(vic_way), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
      .ent_we(ent_we), .ent_way(ent_way), .ent_valid(ent_valid), .ent_dirty(ent_dirty),
      .lru_we(lru_we), .lru_val(lru_val)
   );

   hwc_data_store #(
      .SETS(SETS), .SET_W(SET_W), .LINE_WORDS(LINE_WORDS), .WSEL_W(WSEL_W),
      .WORD_W(WORD_W), .LINE_W(LINE_W)
   ) u_data (
      .clk(clk), .set(lk_set), .word_sel(word_sel),
      .rd_way(d_rd_way), .rd_line(d_rd_line), .rd_word(d_rd_word),
      .wr_way(ent_way), .line_we(d_line_we), .line_wdata(d_line_wdata),
      .word_we(d_word_we), .word_wdata(d_word_wdata)
   );

endmodule

// File: tb/sim_hint_wb_cache.sv
module sim_hint_wb_cache;

   localparam logic [2:0] C_LOAD = 3'd0, C_STORE = 3'd1, C_PREF = 3'd2, C_ZERO = 3'd3,
                          C_INVAL = 3'd4, C_FLUSH = 3'd5, C_LAST = 3'd6;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_valid = 1'b0;
   logic         cpu_ready;
   logic [2:0]   cpu_op = 3'd0;
   logic [15:0]  cpu_addr = '0;
   logic [31:0]  cpu_wdata = '0;
   logic [31:0]  cpu_rdata;
   logic         cpu_rvalid;
   logic         mem_req, mem_we;
   logic [15:0]  mem_addr;
   logic [127:0] mem_wdata;
   logic         mem_ack = 1'b0;
   logic [127:0] mem_rdata = '0;

   logic [127:0] mem_line [64];
   int rd_cnt = 0, wr_cnt = 0;
   int n_chk = 0, n_fail = 0;
   logic        g_rv;
   logic [31:0] g_data;
   int          g_cyc;

   always #10 clk = ~clk;

   hint_wb_cache u0 (
      .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
      .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] init_word(int line, int word);
      return 32'hA000_0000 | (32'(line) << 8) | 32'(word);
   endfunction

   initial begin
      for (int l = 0; l < 64; l++)
         for (int w = 0; w < 4; w++) mem_line[l][w*32 +: 32] = init_word(l, w);
   end

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
         if (mem_we) begin
            mem_line[mem_addr[9:4]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem_line[mem_addr[9:4]];
            rd_cnt <= rd_cnt + 1;
         end
         mem_ack <= 1'b1;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cmd(logic [2:0] op, logic [15:0] addr, logic [31:0] wd);
      @(negedge clk);
      cpu_valid = 1'b1; cpu_op = op; cpu_addr = addr; cpu_wdata = wd;
      while (!cpu_ready) @(negedge clk);
      @(negedge clk);
      cpu_valid = 1'b0;
      g_cyc = 0; g_rv = 1'b0;
      while (!cpu_ready) begin
         @(negedge clk);
         g_cyc++;
         if (cpu_rvalid) g_rv = 1'b1;
      end
      g_data = cpu_rdata;
   endtask

   task automatic t_reset();
      check("R12 ready after reset", 32'(cpu_ready), 32'd1);
      check("R12 no mem_req after reset", 32'(mem_req), 32'd0);
      check("R12 no rvalid after reset", 32'(cpu_rvalid), 32'd0);
   endtask

   task automatic t_load();
      int r0 = rd_cnt;
      cmd(C_LOAD, 16'h0004, 0);
      check("R1 miss data", g_data, init_word(0, 1));
      check("R1 miss rvalid", 32'(g_rv), 1);
      check("R1 miss one read", 32'(rd_cnt - r0), 1);
      check("R11 clean miss busy cycles", 32'(g_cyc), 4);
      cmd(C_LOAD, 16'h000C, 0);
      check("R1 hit data", g_data, init_word(0, 3));
      check("R1 hit latency", 32'(g_cyc), 1);
      check("R1 hit no read", 32'(rd_cnt - r0), 1);
   endtask

   task automatic t_store();
      int w0 = wr_cnt;
      cmd(C_STORE, 16'h0008, 32'hDEAD_0008);
      check("R2 store no rvalid", 32'(g_rv), 0);
      cmd(C_LOAD, 16'h0008, 0);
      check("R2 store readback", g_data, 32'hDEAD_0008);
      check("R2 no write yet", 32'(wr_cnt - w0), 0);
      check("R2 memory unchanged", mem_line[0][64 +: 32], init_word(0, 2));
   endtask

   task automatic t_evict();
      int r0, w0;
      cmd(C_LOAD, 16'h0080, 0);
      r0 = rd_cnt; w0 = wr_cnt;
      cmd(C_LOAD, 16'h0100, 0);
      check("R4 dirty victim written", 32'(wr_cnt - w0), 1);
      check("R4 written line content", mem_line[0][64 +: 32], 32'hDEAD_0008);
      check("R4 other word written", mem_line[0][0 +: 32], init_word(0, 0));
      check("R4 fill after writeback", g_data, init_word(16, 0));
      check("R4 one read", 32'(rd_cnt - r0), 1);
      cmd(C_LOAD, 16'h0080, 0);
      check("R3 mru way kept", 32'(rd_cnt - r0), 1);
      w0 = wr_cnt;
      cmd(C_LOAD, 16'h0180, 0);
      check("R4 clean victim no write", 32'(wr_cnt - w0), 0);
      r0 = rd_cnt;
      cmd(C_LOAD, 16'h0084, 0);
      check("R3 lru victim was other way", 32'(rd_cnt - r0), 0);
      check("R3 hit data", g_data, init_word(8, 1));
   endtask

   task automatic t_prefetch();
      int r0 = rd_cnt;
      cmd(C_PREF, 16'h0210, 0);
      check("R5 prefetch no rvalid", 32'(g_rv), 0);
      check("R5 prefetch reads once", 32'(rd_cnt - r0), 1);
      cmd(C_LOAD, 16'h0214, 0);
      check("R5 prefetched hit", 32'(rd_cnt - r0), 1);
      check("R5 prefetched data", g_data, init_word(33, 1));
      cmd(C_PREF, 16'h0210, 0);
      check("R5 present prefetch no traffic", 32'(rd_cnt - r0), 1);
   endtask

   task automatic t_zero();
      int r0 = rd_cnt, w0 = wr_cnt;
      cmd(C_ZERO, 16'h0320, 0);
      check("R6 zero no read", 32'(rd_cnt - r0), 0);
      check("R6 zero no write", 32'(wr_cnt - w0), 0);
      cmd(C_LOAD, 16'h0324, 0);
      check("R6 zero data", g_data, 32'h0);
      cmd(C_FLUSH, 16'h0320, 0);
      check("R8 dirty flush writes", 32'(wr_cnt - w0), 1);
      check("R6 zero line was dirty", mem_line[50][32 +: 32], 32'h0);
      cmd(C_LOAD, 16'h0324, 0);
      check("R8 flushed line misses", 32'(rd_cnt - r0), 1);
      check("R8 data after flush", g_data, 32'h0);
   endtask

   task automatic t_inval();
      int r0, w0;
      cmd(C_STORE, 16'h0034, 32'h1234_5678);
      r0 = rd_cnt; w0 = wr_cnt;
      cmd(C_INVAL, 16'h0030, 0);
      check("R7 invalidate dirty no write", 32'(wr_cnt - w0), 0);
      cmd(C_LOAD, 16'h0034, 0);
      check("R7 memory copy seen", g_data, init_word(3, 1));
      check("R7 refetched", 32'(rd_cnt - r0), 1);
   endtask

   task automatic t_flush_clean();
      int r0, w0;
      cmd(C_LOAD, 16'h0040, 0);
      r0 = rd_cnt; w0 = wr_cnt;
      cmd(C_FLUSH, 16'h0040, 0);
      check("R8 clean flush no traffic", 32'((rd_cnt - r0) + (wr_cnt - w0)), 0);
      cmd(C_LOAD, 16'h0040, 0);
      check("R8 clean flush then miss", 32'(rd_cnt - r0), 1);
   endtask

   task automatic t_absent();
      int r0 = rd_cnt, w0 = wr_cnt;
      cmd(C_INVAL, 16'h03C0, 0);
      check("R9 absent invalidate no rvalid", 32'(g_rv), 0);
      cmd(C_FLUSH, 16'h03C0, 0);
      check("R9 absent ops no traffic", 32'((rd_cnt - r0) + (wr_cnt - w0)), 0);
      cmd(C_LOAD, 16'h0040, 0);
      check("R9 neighbour line untouched", 32'(rd_cnt - r0), 0);
   endtask

   task automatic t_loadlast();
      int r0;
      cmd(C_LOAD, 16'h0050, 0);
      cmd(C_LOAD, 16'h00D0, 0);
      cmd(C_LAST, 16'h00D4, 0);
      check("R10 load-last data", g_data, init_word(13, 1));
      check("R10 load-last rvalid", 32'(g_rv), 1);
      cmd(C_LOAD, 16'h0150, 0);
      r0 = rd_cnt;
      cmd(C_LOAD, 16'h0050, 0);
      check("R10 older line kept", 32'(rd_cnt - r0), 0);
      cmd(C_LOAD, 16'h00D0, 0);
      check("R10 load-last line evicted", 32'(rd_cnt - r0), 1);
      r0 = rd_cnt;
      cmd(C_LAST, 16'h0068, 0);
      check("R10 load-last miss fills", 32'(rd_cnt - r0), 1);
      check("R10 load-last miss data", g_data, init_word(6, 2));
   endtask

   task automatic t_store_lru();
      int r0, w0;
      r0 = rd_cnt;
      cmd(C_STORE, 16'h0070, 32'h7777_7777);
      check("R2 store miss allocates", 32'(rd_cnt - r0), 1);
      cmd(C_LOAD, 16'h00F0, 0);
      cmd(C_STORE, 16'h0074, 32'h7474_7474);
      w0 = wr_cnt; r0 = rd_cnt;
      cmd(C_LOAD, 16'h0170, 0);
      check("R3 store made way mru", 32'(wr_cnt - w0), 0);
      cmd(C_LOAD, 16'h0070, 0);
      check("R2 stored word kept", g_data, 32'h7777_7777);
      cmd(C_LOAD, 16'h0078, 0);
      check("R2 other words from memory", g_data, init_word(7, 2));
      check("R3 stored line stayed", 32'(rd_cnt - r0), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_store();
      t_evict();
      t_prefetch();
      t_zero();
      t_inval();
      t_flush_clean();
      t_absent();
      t_loadlast();
      t_store_lru();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule